// File: doc/BRIEF.md
# Masked Time-of-Day Alarm

This block raises an alarm when the running calendar time reaches a programmed moment. It holds three alarm bytes (minutes, hours, day of week) and a command byte on a small register bus. It compares the alarm bytes against time values that a separate clock core supplies. The top bit of each alarm byte excludes that field from the compare. Setting the masks from the day field upward gives a repeat every week, every day, every hour, or, with all three set, every minute.

The compare runs only on the 100 Hz tick where the hundredths input reads 99, which is the boundary between seconds, so one matching time produces one event. An event sets a flag that software reads in the command byte and drives an interrupt. In level mode the interrupt stays high until software touches an alarm byte. In pulse mode it is released after a fixed number of clock cycles. A command bit picks which of two outputs carries the alarm, and a watchdog interrupt from a neighbouring block takes the other output. Both outputs are active high. Driving the pins electrically is left to the pad ring.

Top module: `tod_alarm`

## Requirements
- R1: After reset, offsets 3, 5, 7 and 0xB all read 0x00, and irq_a and irq_b are low while wdog_irq_i is low.
- R2: A write to offset 3 or 5 stores the whole byte. A write to offset 7 stores bits 7 and 2..0, and bits 6..3 read 0. Offset 0xB stores bits 6 (route), 4 (pulse) and 2 (interrupt mask). Its bit 0 is the read-only alarm flag, and its other bits read 0. Any other offset reads 0x00.
- R3: With bit 7 clear in all three alarm bytes, an event occurs on a tick with hund_i = 0x99 and sec_i = 0x00 when min_i[6:0], hour_i[6:0] and day_i[2:0] equal the corresponding alarm fields.
- R4: With only the day mask set, the day field is ignored and minutes and hours must match.
- R5: With the day and hour masks set, only minutes must match.
- R6: With all three masks set, an event occurs on a tick with hund_i = 0x99 and sec_i = 0x59, whatever the other fields hold.
- R7: No event occurs unless tick_i is high and hund_i is 0x99 in the same cycle.
- R8: In level mode (bit 4 = 0), the flag and the alarm interrupt stay set until a read or a write of offset 3, 5 or 7. Accesses to other offsets do not clear them.
- R9: In pulse mode (bit 4 = 1), the flag and the interrupt are high for exactly PULSE_CYCLES clock cycles after the event and then release by themselves.
- R10: With bit 2 set, an event sets the flag but the alarm interrupt stays low on both outputs.
- R11: With bit 6 = 1, the alarm drives irq_a and wdog_irq_i drives irq_b. With bit 6 = 0, the two are swapped.
- R12: When an event and a clearing access to an alarm byte happen in the same cycle, the event wins and the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle 100 Hz strobe from the clock core |
| hund_i | input | 8 | Hundredths of a second, BCD |
| sec_i | input | 8 | Seconds, BCD |
| min_i | input | 8 | Minutes, BCD |
| hour_i | input | 8 | Hours, register format |
| day_i | input | 8 | Day of week, bits 2..0 |
| bus_en | input | 1 | One-cycle register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| wdog_irq_i | input | 1 | Watchdog interrupt to be routed |
| irq_a | output | 1 | Interrupt output A, active high |
| irq_b | output | 1 | Interrupt output B, active high |

## Verification
Two functions can fall in the same cycle: a compare hit on the second boundary and a read of an alarm byte, which clears the flag. The bench forces this by driving the boundary tick with matching time while it reads offset 3 in the same cycle. It judges the result by the flag reading 1 afterwards, with the alarm interrupt still high. A separate access with no hit must clear both, which shows that the clear path works and is only outranked.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int unsigned DW          = 8;
    localparam int unsigned ADR_AMIN    = 3;
    localparam int unsigned ADR_AHOUR   = 5;
    localparam int unsigned ADR_ADAY    = 7;
    localparam int unsigned ADR_CMD     = 11;

    localparam logic [DW-1:0] HUND_LAST = 8'h99;
    localparam logic [DW-1:0] SEC_LAST  = 8'h59;
    localparam logic [DW-1:0] SEC_FIRST = 8'h00;

    localparam logic [DW-1:0] MIN_BITS  = 8'h7F;
    localparam logic [DW-1:0] HOUR_BITS = 8'h7F;
    localparam logic [DW-1:0] DAY_BITS  = 8'h07;

    localparam int unsigned CMD_ROUTE_BIT = 6;
    localparam int unsigned CMD_PULSE_BIT = 4;
    localparam int unsigned CMD_MASK_BIT  = 2;
    localparam int unsigned CMD_FLAG_BIT  = 0;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] day;
    } tod_time_t;

    typedef struct packed {
        logic [DW-1:0] amin;
        logic [DW-1:0] ahour;
        logic [DW-1:0] aday;
    } alarm_regs_t;

    typedef struct packed {
        logic route_a;
        logic pulse;
        logic irq_mask;
    } ctrl_t;

    // Field passes when its mask bit is set or its live bits are equal.
    function automatic logic field_ok(input logic [DW-1:0] alarm,
                                      input logic [DW-1:0] now,
                                      input logic [DW-1:0] bits);
        return alarm[DW-1] | ((alarm & bits) == (now & bits));
    endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              flag,
    output logic [DW-1:0]     bus_rdata,
    output alarm_regs_t       alm,
    output ctrl_t             ctl,
    output logic              alarm_access
);

    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ADR_AMIN);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(ADR_AHOUR);
    localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(ADR_ADAY);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADR_CMD);

    logic wr;
    assign wr = bus_en && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm <= '0;
            ctl <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_MIN:  alm.amin  <= bus_wdata;
                A_HOUR: alm.ahour <= bus_wdata;
                A_DAY:  alm.aday  <= (bus_wdata & (DAY_BITS | 8'h80));
                A_CMD: begin
                    ctl.route_a  <= bus_wdata[CMD_ROUTE_BIT];
                    ctl.pulse    <= bus_wdata[CMD_PULSE_BIT];
                    ctl.irq_mask <= bus_wdata[CMD_MASK_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MIN:  bus_rdata = alm.amin;
            A_HOUR: bus_rdata = alm.ahour;
            A_DAY:  bus_rdata = alm.aday;
            A_CMD: begin
                bus_rdata[CMD_ROUTE_BIT] = ctl.route_a;
                bus_rdata[CMD_PULSE_BIT] = ctl.pulse;
                bus_rdata[CMD_MASK_BIT]  = ctl.irq_mask;
                bus_rdata[CMD_FLAG_BIT]  = flag;
            end
            default: ;
        endcase
    end

    assign alarm_access = bus_en &&
        (bus_addr == A_MIN || bus_addr == A_HOUR || bus_addr == A_DAY);

    // R2: a minutes write is visible in the stored byte on the next cycle
    a_r2_amin_store: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == A_MIN |=> alm.amin == $past(bus_wdata));

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic          tick_i,
    input  logic [DW-1:0] hund_i,
    input  tod_time_t     now,
    input  alarm_regs_t   alm,
    output logic          evt
);

    logic boundary;
    logic all_masked;
    logic [2:0] fld_hit;
    logic per_minute;
    logic per_match;

    assign boundary   = tick_i && (hund_i == HUND_LAST);
    assign all_masked = alm.amin[DW-1] & alm.ahour[DW-1] & alm.aday[DW-1];

    assign fld_hit[0] = field_ok(alm.amin,  now.min,  MIN_BITS);
    assign fld_hit[1] = field_ok(alm.ahour, now.hour, HOUR_BITS);
    assign fld_hit[2] = field_ok(alm.aday,  now.day,  DAY_BITS);

    assign per_minute = all_masked && (now.sec == SEC_LAST);
    assign per_match  = !all_masked && (now.sec == SEC_FIRST) && (&fld_hit);
    assign evt        = boundary && (per_minute || per_match);

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
    import tod_alarm_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 30000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  evt,
    input  logic  clr,
    input  ctrl_t ctl,
    input  logic  wdog_irq_i,
    output logic  flag,
    output logic  irq_a,
    output logic  irq_b
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             tod_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (evt) begin
            active <= 1'b1;
            cnt    <= CNT_W'(PULSE_CYCLES - 1);
        end else if (clr) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (ctl.pulse && active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign flag    = active;
    assign tod_irq = active && !ctl.irq_mask;
    assign irq_a   = ctl.route_a ? tod_irq    : wdog_irq_i;
    assign irq_b   = ctl.route_a ? wdog_irq_i : tod_irq;

    // R8: an alarm-byte access without a new hit drops the pending alarm
    a_r8_access_clears: assert property (@(posedge clk) disable iff (rst)
        clr && !evt |=> !active);

    // R8: level mode holds the alarm while nothing clears it
    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        !ctl.pulse && active && !clr |=> active);

    // R12: a hit always leaves the alarm pending, even against a clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt |=> active);

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned PULSE_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [7:0]        hund_i,
    input  logic [7:0]        sec_i,
    input  logic [7:0]        min_i,
    input  logic [7:0]        hour_i,
    input  logic [7:0]        day_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              wdog_irq_i,
    output logic              irq_a,
    output logic              irq_b
);

    tod_time_t   now;
    alarm_regs_t alm;
    ctrl_t       ctl;
    logic        evt;
    logic        flag;
    logic        clr;

    assign now = '{sec: sec_i, min: min_i, hour: hour_i, day: day_i};

    tod_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .flag         (flag),
        .bus_rdata    (bus_rdata),
        .alm          (alm),
        .ctl          (ctl),
        .alarm_access (clr)
    );

    tod_alarm_match u_match (
        .tick_i (tick_i),
        .hund_i (hund_i),
        .now    (now),
        .alm    (alm),
        .evt    (evt)
    );

    tod_alarm_irq #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .clr        (clr),
        .ctl        (ctl),
        .wdog_irq_i (wdog_irq_i),
        .flag       (flag),
        .irq_a      (irq_a),
        .irq_b      (irq_b)
    );

    // R7: hits only appear on the second-boundary tick
    a_r7_boundary_only: assert property (@(posedge clk) disable iff (rst)
        evt |-> tick_i && hund_i == HUND_LAST);

    // R10: the interrupt mask keeps the alarm off both pins
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        ctl.irq_mask && !wdog_irq_i |-> !irq_a && !irq_b);

    // R11: without a watchdog request at most one pin is high
    a_r11_one_pin: assert property (@(posedge clk) disable iff (rst)
        !wdog_irq_i |-> !(irq_a && irq_b));

endmodule

// File: tb/tod_alarm_bench.sv
module tod_alarm_bench;

    localparam int unsigned PULSE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [7:0] hund_i = '0, sec_i = '0, min_i = '0, hour_i = '0, day_i = '0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wdog_irq_i = 1'b0;
    logic       irq_a, irq_b;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    tod_alarm #(.ADDR_W(4), .PULSE_CYCLES(PULSE)) u_tod_alarm (
        .clk(clk), .rst(rst), .tick_i(tick_i), .hund_i(hund_i),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .day_i(day_i),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_irq_i(wdog_irq_i), .irq_a(irq_a), .irq_b(irq_b)
    );

    typedef struct packed {
        logic [7:0] amin, ahr, aday, sec, mn, hr, dy, hund;
        logic       tk;
        logic       ex;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h03, 8'h99, 1'b1, 1'b1}, // R3 full match
        '{8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h04, 8'h99, 1'b1, 1'b0}, // R3 day differs
        '{8'h30, 8'h12, 8'h03, 8'h01, 8'h30, 8'h12, 8'h03, 8'h99, 1'b1, 1'b0}, // R3 not second 00
        '{8'h30, 8'h12, 8'h83, 8'h00, 8'h30, 8'h12, 8'h05, 8'h99, 1'b1, 1'b1}, // R4 day ignored
        '{8'h30, 8'h12, 8'h83, 8'h00, 8'h30, 8'h13, 8'h05, 8'h99, 1'b1, 1'b0}, // R4 hour differs
        '{8'h30, 8'h92, 8'h83, 8'h00, 8'h30, 8'h07, 8'h01, 8'h99, 1'b1, 1'b1}, // R5 minutes only
        '{8'h30, 8'h92, 8'h83, 8'h00, 8'h31, 8'h07, 8'h01, 8'h99, 1'b1, 1'b0}, // R5 minute differs
        '{8'hB0, 8'h92, 8'h83, 8'h59, 8'h11, 8'h05, 8'h06, 8'h99, 1'b1, 1'b1}, // R6 every minute
        '{8'hB0, 8'h92, 8'h83, 8'h00, 8'h30, 8'h12, 8'h03, 8'h99, 1'b1, 1'b0}, // R6 wrong second
        '{8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h03, 8'h98, 1'b1, 1'b0}, // R7 hund not 99
        '{8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h03, 8'h99, 1'b0, 1'b0}, // R7 no tick
        '{8'h45, 8'h23, 8'h07, 8'h00, 8'h45, 8'h23, 8'h07, 8'h99, 1'b1, 1'b1}  // R3 24h late
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    // all-masks alarm fires at second 59 boundary
    task automatic fire();
        sec_i = 8'h59; hund_i = 8'h99; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0; hund_i = 8'h00;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h3, rv); chk("R1 amin", rv, 8'h00);
        rd(4'h5, rv); chk("R1 ahour", rv, 8'h00);
        rd(4'h7, rv); chk("R1 aday", rv, 8'h00);
        rd(4'hB, rv); chk("R1 cmd", rv, 8'h00);
        chk("R1 irqs", {irq_a, irq_b}, 2'b00);

        // R2 register map
        wr(4'h3, 8'hA5); rd(4'h3, rv); chk("R2 amin", rv, 8'hA5);
        wr(4'h7, 8'hFF); rd(4'h7, rv); chk("R2 aday", rv, 8'h87);
        wr(4'hB, 8'hFF); rd(4'hB, rv); chk("R2 cmd", rv, 8'h54);
        wr(4'hB, 8'h00);
        rd(4'h0, rv); chk("R2 unused", rv, 8'h00);

        // R3..R7 compare table, level mode, alarm on irq_b
        for (int i = 0; i < NV; i++) begin
            wr(4'h3, VECS[i].amin);
            wr(4'h5, VECS[i].ahr);
            wr(4'h7, VECS[i].aday);
            sec_i = VECS[i].sec; min_i = VECS[i].mn;
            hour_i = VECS[i].hr; day_i = VECS[i].dy;
            hund_i = VECS[i].hund; tick_i = VECS[i].tk;
            @(negedge clk);
            tick_i = 1'b0; hund_i = 8'h00;
            chk($sformatf("R3-7 vec%0d irq_b", i), irq_b, VECS[i].ex);
            rd(4'hB, rv);
            chk($sformatf("R3-7 vec%0d flag", i), rv[0], VECS[i].ex);
        end

        // R8 level hold and selective clear
        wr(4'h3, 8'hB0); wr(4'h5, 8'h92); wr(4'h7, 8'h83);
        fire();
        repeat (10) @(negedge clk);
        rd(4'h4, rv); rd(4'hB, rv);
        chk("R8 held", rv[0], 1'b1);
        chk("R8 irq held", irq_b, 1'b1);
        rd(4'h5, rv);
        rd(4'hB, rv);
        chk("R8 cleared", rv[0], 1'b0);
        chk("R8 irq cleared", irq_b, 1'b0);

        // R12 hit and clearing read in the same cycle
        sec_i = 8'h59; hund_i = 8'h99; tick_i = 1'b1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 4'h3;
        @(negedge clk);
        tick_i = 1'b0; hund_i = 8'h00; bus_en = 1'b0;
        rd(4'hB, rv);
        chk("R12 flag", rv[0], 1'b1);
        chk("R12 irq", irq_b, 1'b1);
        rd(4'h3, rv);

        // R10 interrupt mask
        wr(4'hB, 8'h04);
        fire();
        chk("R10 pins", {irq_a, irq_b}, 2'b00);
        rd(4'hB, rv); chk("R10 flag", rv[0], 1'b1);
        rd(4'h3, rv);

        // R11 routing
        wr(4'hB, 8'h40);
        fire();
        chk("R11 route1", {irq_a, irq_b}, 2'b10);
        wdog_irq_i = 1'b1; #1;
        chk("R11 route1 wdog", {irq_a, irq_b}, 2'b11);
        wdog_irq_i = 1'b0;
        wr(4'hB, 8'h00); #1;
        chk("R11 route0", {irq_a, irq_b}, 2'b01);
        wdog_irq_i = 1'b1; #1;
        chk("R11 route0 wdog", {irq_a, irq_b}, 2'b11);
        wdog_irq_i = 1'b0;
        @(negedge clk);
        rd(4'h3, rv);

        // R9 pulse width
        wr(4'hB, 8'h50);
        begin
            int n;
            fire();
            n = irq_a ? 1 : 0;
            repeat (19) begin
                @(negedge clk);
                if (irq_a) n++;
            end
            chk("R9 width", n, PULSE);
            rd(4'hB, rv); chk("R9 flag released", rv[0], 1'b0);
            fire();
            rd(4'hB, rv); chk("R9 flag during pulse", rv[0], 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule